// File: doc/BRIEF.md
# Tagged Paired-Register Store Unit

This block takes one 32-bit instruction word and carries out the store it describes. Two 64-bit registers are written to memory as one 128-bit word. The 4-bit allocation tag for the 16-byte granule that receives the data is also written. The tag value comes from the logical tag field of the access address. The block reads its operands through three register-file read ports and a stack-pointer input. Memory traffic leaves through a data-write port and a tag-write port, each with a valid/ready handshake. The new base value goes back through a writeback port.

Three address forms exist. Plain offset computes base plus offset and never writes the base back. Pre-indexed computes base plus offset, uses that address for the access, and writes that same address back. Post-indexed uses the unmodified base for the access and writes base plus offset back. The offset is a signed 7-bit field scaled by the granule size. An access address that is not granule aligned aborts the operation before anything is written. If the feature-enable input is low, a matching encoding is reported as undefined.

A controller pulses `start` with the word. It then waits for the one-cycle `done` pulse and reads `fault_align` and `undef` in that same cycle. While `busy` is high, further `start` pulses are ignored.

Top module: `tagpair_store_unit`

## Requirements
- R1: A word is recognised only when bits[31:30]=01, bits[29:27]=101, bit26=0, bit25=0, bit22=0 and the mode field bits[24:23] is not 00. Any other word ends with a `done` pulse that has `fault_align`=0 and `undef`=0, and no data, tag or writeback transfer takes place.
- R2: A recognised word with `feat_en` low ends with `done` and `undef`=1. No data, tag or writeback transfer takes place.
- R3: The offset is the 7-bit field bits[21:15], sign-extended and multiplied by 16, so it ranges from -1024 to +1008. In plain-offset mode (bits[24:23]=10), the data is written at base+offset and no writeback occurs.
- R4: In pre-indexed mode (bits[24:23]=11), the data is written at base+offset and the same value is written back to the base register.
- R5: In post-indexed mode (bits[24:23]=01), the data is written at the unmodified base and base+offset is written back.
- R6: The base index is bits[9:5]. Index 31 selects `sp_in` as the base, and the writeback then goes to the stack pointer with `wb_to_sp`=1. Any other index selects that general register, and `wb_idx` carries the index.
- R7: If the access address has any of bits[3:0] set, or if the stack pointer is selected as base and is not 16-byte aligned, the operation ends with `done` and `fault_align`=1. No data, tag or writeback transfer takes place.
- R8: The first data register index is bits[4:0] and the second is bits[14:10]. With `big_endian`=1 the 128-bit word is {first, second}; otherwise it is {second, first}. The left half occupies bits[127:64].
- R9: After the data transfer completes, exactly one tag transfer follows. `tw_gran` carries access address bits[63:4] and `tw_tag` carries access address bits[59:56].
- R10: A data register index of 31 supplies zero, not the stack pointer.
- R11: `dw_valid` and `tw_valid` stay high, with their payload unchanged, until the matching ready input is sampled high. At most one of the data, tag and writeback strobes is active in any cycle.
- R12: After reset, `busy`, `done` and all transfer strobes are low. Each accepted `start` yields exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept `instr` when the block is idle |
| instr | input | 32 | Instruction word |
| feat_en | input | 1 | Feature enable; when low, recognised words are undefined |
| big_endian | input | 1 | Data ordering select |
| rf_ra_t | output | 5 | Read address, first data register |
| rf_ra_t2 | output | 5 | Read address, second data register |
| rf_ra_n | output | 5 | Read address, base register |
| rf_rd_t | input | 64 | Read data, first data register |
| rf_rd_t2 | input | 64 | Read data, second data register |
| rf_rd_n | input | 64 | Read data, base register |
| sp_in | input | 64 | Current stack pointer |
| dw_valid | output | 1 | Data write request |
| dw_ready | input | 1 | Data write accepted |
| dw_addr | output | 64 | Data write byte address |
| dw_data | output | 128 | Data write payload |
| tw_valid | output | 1 | Tag write request |
| tw_ready | input | 1 | Tag write accepted |
| tw_gran | output | 60 | Granule index for the tag |
| tw_tag | output | 4 | Allocation tag value |
| wb_valid | output | 1 | Base writeback strobe, one cycle |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback general register index |
| wb_value | output | 64 | Writeback value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, one cycle |
| fault_align | output | 1 | Alignment fault, valid with `done` |
| undef | output | 1 | Undefined instruction, valid with `done` |

## Verification
The bench targets several edges of the offset and address logic:

- The offset extremes, -1024 and +1008. A design that zero-extends the field or shifts it by the wrong amount writes to the wrong address.
- Post-indexing. A design that applies the offset before the access, instead of only to the writeback value, writes to the wrong place.
- Base index 31. A design that confuses the stack pointer with register 31 reads the wrong base or writes back to the wrong target.
- A data index of 31. A design that treats it as the stack pointer stores a nonzero word where zero is expected.
- A misaligned general base and a misaligned stack pointer. A design that fails to abort leaves stray data or tag writes.

The bench also checks the other behaviours that are easy to get wrong:

- Both endian orders. A swap error shows up as exchanged halves in the stored word.
- A base whose bits[59:56] carry a nonzero tag. A design that takes the tag from the wrong bits writes the wrong tag.
- Stalled ready inputs. A design that drops or repeats a transfer under stall produces the wrong transfer count.
- Feature disable and non-matching words. Either one must produce no transfer.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int INSTR_W = 32;
    localparam int RIDX_W  = 5;
    localparam int OFS_W   = 7;

    typedef enum logic [1:0] {
        AM_NONE = 2'b00,
        AM_POST = 2'b01,
        AM_OFF  = 2'b10,
        AM_PRE  = 2'b11
    } amode_e;

    typedef struct packed {
        logic              hit;
        amode_e            mode;
        logic [OFS_W-1:0]  ofs;
        logic [RIDX_W-1:0] r_second;
        logic [RIDX_W-1:0] r_base;
        logic [RIDX_W-1:0] r_first;
    } dec_s;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_DATA,
        ST_TAG,
        ST_WB,
        ST_DONE
    } state_e;

    function automatic logic writes_back(input amode_e m);
        return (m == AM_PRE) || (m == AM_POST);
    endfunction

endpackage

// File: rtl/tps_decode.sv
module tps_decode
    import tps_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output dec_s               dec
);
    logic fixed_ok;

    always_comb begin
        fixed_ok = (word[31:30] == 2'b01) && (word[29:27] == 3'b101) &&
                   !word[26] && !word[25] && !word[22];
        dec.mode     = amode_e'(word[24:23]);
        dec.hit      = fixed_ok && (word[24:23] != 2'b00);
        dec.ofs      = word[21:15];
        dec.r_second = word[14:10];
        dec.r_base   = word[9:5];
        dec.r_first  = word[4:0];
    end
endmodule

// File: rtl/tps_agen.sv
module tps_agen
    import tps_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int GRAN_LOG2 = 4,
    parameter int IMM_W     = 7
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] ofs,
    input  amode_e           mode,
    output logic [XLEN-1:0]  acc_addr,
    output logic [XLEN-1:0]  next_base,
    output logic             misaligned
);
    localparam int EXT_W = XLEN - IMM_W - GRAN_LOG2;

    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] sum;

    always_comb begin
        scaled     = {{EXT_W{ofs[IMM_W-1]}}, ofs, {GRAN_LOG2{1'b0}}};
        sum        = base + scaled;
        acc_addr   = (mode == AM_POST) ? base : sum;
        next_base  = sum;
        misaligned = |acc_addr[GRAN_LOG2-1:0];
    end
endmodule

// File: rtl/tps_pack.sv
module tps_pack #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   first_val,
    input  logic [XLEN-1:0]   second_val,
    input  logic              big_endian,
    output logic [2*XLEN-1:0] word
);
    always_comb begin
        if (big_endian) word = {first_val, second_val};
        else            word = {second_val, first_val};
    end
endmodule

// File: rtl/tagpair_store_unit.sv
module tagpair_store_unit
    import tps_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int GRAN_LOG2 = 4,
    parameter int TAG_W     = 4,
    parameter int TAG_LSB   = 56,
    localparam int DATA_W   = 2 * XLEN,
    localparam int GRAN_W   = XLEN - GRAN_LOG2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [31:0]        instr,
    input  logic               feat_en,
    input  logic               big_endian,
    output logic [4:0]         rf_ra_t,
    output logic [4:0]         rf_ra_t2,
    output logic [4:0]         rf_ra_n,
    input  logic [XLEN-1:0]    rf_rd_t,
    input  logic [XLEN-1:0]    rf_rd_t2,
    input  logic [XLEN-1:0]    rf_rd_n,
    input  logic [XLEN-1:0]    sp_in,
    output logic               dw_valid,
    input  logic               dw_ready,
    output logic [XLEN-1:0]    dw_addr,
    output logic [DATA_W-1:0]  dw_data,
    output logic               tw_valid,
    input  logic               tw_ready,
    output logic [GRAN_W-1:0]  tw_gran,
    output logic [TAG_W-1:0]   tw_tag,
    output logic               wb_valid,
    output logic               wb_to_sp,
    output logic [4:0]         wb_idx,
    output logic [XLEN-1:0]    wb_value,
    output logic               busy,
    output logic               done,
    output logic               fault_align,
    output logic               undef
);
    localparam logic [RIDX_W-1:0] ZR_IDX = '1;

    state_e              state_q;
    logic [INSTR_W-1:0]  ir_q;
    logic                fe_q;
    logic                be_q;
    logic [XLEN-1:0]     acc_q;
    logic [XLEN-1:0]     wbv_q;
    logic [DATA_W-1:0]   data_q;
    logic                fault_q;
    logic                undef_q;

    dec_s                dec;
    logic [XLEN-1:0]     first_val;
    logic [XLEN-1:0]     second_val;
    logic [XLEN-1:0]     base_val;
    logic                base_is_sp;
    logic                sp_bad;
    logic [XLEN-1:0]     acc_addr;
    logic [XLEN-1:0]     next_base;
    logic                misaligned;
    logic [DATA_W-1:0]   packed_word;

    tps_decode u_dec (
        .word (ir_q),
        .dec  (dec)
    );

    always_comb begin
        rf_ra_t    = dec.r_first;
        rf_ra_t2   = dec.r_second;
        rf_ra_n    = dec.r_base;
        first_val  = (dec.r_first  == ZR_IDX) ? '0 : rf_rd_t;
        second_val = (dec.r_second == ZR_IDX) ? '0 : rf_rd_t2;
        base_is_sp = (dec.r_base == ZR_IDX);
        base_val   = base_is_sp ? sp_in : rf_rd_n;
        sp_bad     = base_is_sp && (|sp_in[GRAN_LOG2-1:0]);
    end

    tps_agen #(
        .XLEN      (XLEN),
        .GRAN_LOG2 (GRAN_LOG2),
        .IMM_W     (OFS_W)
    ) u_agen (
        .base       (base_val),
        .ofs        (dec.ofs),
        .mode       (dec.mode),
        .acc_addr   (acc_addr),
        .next_base  (next_base),
        .misaligned (misaligned)
    );

    tps_pack #(
        .XLEN (XLEN)
    ) u_pack (
        .first_val  (first_val),
        .second_val (second_val),
        .big_endian (be_q),
        .word       (packed_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ir_q    <= '0;
            fe_q    <= 1'b0;
            be_q    <= 1'b0;
            acc_q   <= '0;
            wbv_q   <= '0;
            data_q  <= '0;
            fault_q <= 1'b0;
            undef_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ir_q    <= instr;
                        fe_q    <= feat_en;
                        be_q    <= big_endian;
                        fault_q <= 1'b0;
                        undef_q <= 1'b0;
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (!dec.hit) begin
                        state_q <= ST_DONE;
                    end else if (!fe_q) begin
                        undef_q <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (misaligned || sp_bad) begin
                        fault_q <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        acc_q   <= acc_addr;
                        wbv_q   <= next_base;
                        data_q  <= packed_word;
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (dw_ready) state_q <= ST_TAG;
                end
                ST_TAG: begin
                    if (tw_ready) state_q <= writes_back(dec.mode) ? ST_WB : ST_DONE;
                end
                ST_WB:   state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dw_valid    = (state_q == ST_DATA);
        dw_addr     = acc_q;
        dw_data     = data_q;
        tw_valid    = (state_q == ST_TAG);
        tw_gran     = acc_q[XLEN-1:GRAN_LOG2];
        tw_tag      = acc_q[TAG_LSB+TAG_W-1:TAG_LSB];
        wb_valid    = (state_q == ST_WB);
        wb_to_sp    = base_is_sp;
        wb_idx      = dec.r_base;
        wb_value    = wbv_q;
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        fault_align = done && fault_q;
        undef       = done && undef_q;
    end
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
    parameter int XLEN      = 64,
    parameter int GRAN_LOG2 = 4,
    parameter int TAG_W     = 4,
    parameter int TAG_LSB   = 56,
    localparam int DATA_W   = 2 * XLEN,
    localparam int GRAN_W   = XLEN - GRAN_LOG2
) (
    input logic              clk,
    input logic              rst,
    input logic              dw_valid,
    input logic              dw_ready,
    input logic [XLEN-1:0]   dw_addr,
    input logic [DATA_W-1:0] dw_data,
    input logic              tw_valid,
    input logic              tw_ready,
    input logic [GRAN_W-1:0] tw_gran,
    input logic [TAG_W-1:0]  tw_tag,
    input logic              wb_valid,
    input logic              busy,
    input logic              done,
    input logic              fault_align,
    input logic              undef
);
    localparam int TAG_OFS = TAG_LSB - GRAN_LOG2;

    assert_dw_hold_R11: assert property (@(posedge clk) disable iff (rst)
        dw_valid && !dw_ready |=> dw_valid && $stable(dw_addr) && $stable(dw_data));

    assert_tw_hold_R11: assert property (@(posedge clk) disable iff (rst)
        tw_valid && !tw_ready |=> tw_valid && $stable(tw_gran) && $stable(tw_tag));

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dw_valid, tw_valid, wb_valid}));

    assert_aligned_access_R7: assert property (@(posedge clk) disable iff (rst)
        dw_valid |-> dw_addr[GRAN_LOG2-1:0] == '0);

    assert_fault_only_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        fault_align |-> done && !undef);

    assert_undef_only_at_end_R2: assert property (@(posedge clk) disable iff (rst)
        undef |-> done && !fault_align);

    assert_tag_matches_addr_R9: assert property (@(posedge clk) disable iff (rst)
        tw_valid |-> tw_tag == tw_gran[TAG_OFS+TAG_W-1:TAG_OFS]);

    assert_tag_after_data_R9: assert property (@(posedge clk) disable iff (rst)
        dw_valid && dw_ready |=> tw_valid);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

bind tagpair_store_unit tps_checker #(
    .XLEN      (XLEN),
    .GRAN_LOG2 (GRAN_LOG2),
    .TAG_W     (TAG_W),
    .TAG_LSB   (TAG_LSB)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dw_valid    (dw_valid),
    .dw_ready    (dw_ready),
    .dw_addr     (dw_addr),
    .dw_data     (dw_data),
    .tw_valid    (tw_valid),
    .tw_ready    (tw_ready),
    .tw_gran     (tw_gran),
    .tw_tag      (tw_tag),
    .wb_valid    (wb_valid),
    .busy        (busy),
    .done        (done),
    .fault_align (fault_align),
    .undef       (undef)
);

// File: tb/tb_tagpair_store_unit.sv
module tb_tagpair_store_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [31:0]  instr = '0;
    logic         feat_en = 1'b1;
    logic         big_endian = 1'b0;
    logic [4:0]   rf_ra_t, rf_ra_t2, rf_ra_n;
    logic [63:0]  rf_rd_t, rf_rd_t2, rf_rd_n;
    logic [63:0]  sp_in = '0;
    logic         dw_valid, tw_valid, wb_valid;
    logic         dw_ready = 1'b1, tw_ready = 1'b1;
    logic [63:0]  dw_addr;
    logic [127:0] dw_data;
    logic [59:0]  tw_gran;
    logic [3:0]   tw_tag;
    logic         wb_to_sp;
    logic [4:0]   wb_idx;
    logic [63:0]  wb_value;
    logic         busy, done, fault_align, undef;

    logic [63:0]  xr [0:31];
    int           checks = 0;
    int           fails = 0;
    int           cyc = 0;
    logic         stall = 1'b0;
    logic         timed_out = 1'b0;

    int           n_dw, n_tw, n_wb, seq, dw_seq, tw_seq;
    logic [63:0]  got_addr;
    logic [127:0] got_data;
    logic [59:0]  got_gran;
    logic [3:0]   got_tag;
    logic         got_to_sp;
    logic [4:0]   got_idx;
    logic [63:0]  got_wbv;

    assign rf_rd_t  = xr[rf_ra_t];
    assign rf_rd_t2 = xr[rf_ra_t2];
    assign rf_rd_n  = xr[rf_ra_n];

    tagpair_store_unit dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .feat_en(feat_en),
        .big_endian(big_endian), .rf_ra_t(rf_ra_t), .rf_ra_t2(rf_ra_t2),
        .rf_ra_n(rf_ra_n), .rf_rd_t(rf_rd_t), .rf_rd_t2(rf_rd_t2),
        .rf_rd_n(rf_rd_n), .sp_in(sp_in), .dw_valid(dw_valid),
        .dw_ready(dw_ready), .dw_addr(dw_addr), .dw_data(dw_data),
        .tw_valid(tw_valid), .tw_ready(tw_ready), .tw_gran(tw_gran),
        .tw_tag(tw_tag), .wb_valid(wb_valid), .wb_to_sp(wb_to_sp),
        .wb_idx(wb_idx), .wb_value(wb_value), .busy(busy), .done(done),
        .fault_align(fault_align), .undef(undef)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ready pattern and transfer monitor in one process, away from the rising edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        dw_ready = !stall || (cyc % 3 == 0);
        tw_ready = !stall || (cyc % 4 == 1);
        if (dw_valid && dw_ready) begin
            n_dw = n_dw + 1; seq = seq + 1; dw_seq = seq;
            got_addr = dw_addr; got_data = dw_data;
        end
        if (tw_valid && tw_ready) begin
            n_tw = n_tw + 1; seq = seq + 1; tw_seq = seq;
            got_gran = tw_gran; got_tag = tw_tag;
        end
        if (wb_valid) begin
            n_wb = n_wb + 1;
            got_to_sp = wb_to_sp; got_idx = wb_idx; got_wbv = wb_value;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_word(input logic [31:0] w, input logic fe, input logic be);
        n_dw = 0; n_tw = 0; n_wb = 0; seq = 0; dw_seq = 0; tw_seq = 0;
        @(negedge clk);
        instr = w; feat_en = fe; big_endian = be; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < WATCHDOG) @(negedge clk);
        if (cyc >= WATCHDOG) timed_out = 1'b1;
    endtask

    function automatic logic [31:0] enc(input logic [1:0] md, input logic [6:0] imm,
                                        input logic [4:0] rt, rt2, rn);
        return {2'b01, 3'b101, 1'b0, 1'b0, md, 1'b0, imm, rt2, rn, rt};
    endfunction

    // full reference model for one recognised instruction
    task automatic do_op(input string req, input logic [1:0] md, input logic [6:0] imm,
                         input logic [4:0] rt, rt2, rn, input logic be, input logic fe);
        logic [63:0]  base, off, acc, nb, v1, v2;
        logic [127:0] word;
        logic         flt, wbk;
        base = (rn == 5'd31) ? sp_in : xr[rn];
        off  = {{53{imm[6]}}, imm, 4'b0};
        nb   = base + off;
        acc  = (md == 2'b01) ? base : nb;
        flt  = (acc[3:0] != 0) || ((rn == 5'd31) && (sp_in[3:0] != 0));
        v1   = (rt  == 5'd31) ? 64'd0 : xr[rt];
        v2   = (rt2 == 5'd31) ? 64'd0 : xr[rt2];
        word = be ? {v1, v2} : {v2, v1};
        wbk  = (md != 2'b10);
        run_word(enc(md, imm, rt, rt2, rn), fe, be);
        chk(undef == !fe, req, "undef", undef, !fe);
        chk(fault_align == (fe && flt), req, "fault", fault_align, fe && flt);
        if (!fe || flt) begin
            chk(n_dw + n_tw + n_wb == 0, req, "transfers", n_dw + n_tw + n_wb, 0);
        end else begin
            chk(n_dw == 1, req, "data count", n_dw, 1);
            chk(got_addr == acc, req, "addr", got_addr, acc);
            chk(got_data == word, req, "data", got_data, word);
            chk(n_tw == 1 && tw_seq > dw_seq, req, "tag order", tw_seq, dw_seq + 1);
            chk(got_gran == acc[63:4], req, "granule", got_gran, acc[63:4]);
            chk(got_tag == acc[59:56], req, "tag", got_tag, acc[59:56]);
            chk(n_wb == (wbk ? 1 : 0), req, "wb count", n_wb, wbk);
            if (wbk) begin
                chk(got_wbv == nb, req, "wb value", got_wbv, nb);
                chk(got_to_sp == (rn == 5'd31), req, "wb to sp", got_to_sp, rn == 5'd31);
                if (rn != 5'd31) chk(got_idx == rn, req, "wb idx", got_idx, rn);
            end
        end
    endtask

    task automatic t_reset;
        chk(!busy && !done && !dw_valid && !tw_valid && !wb_valid, "R12", "reset idle",
            {busy, done, dw_valid, tw_valid, wb_valid}, 0);
    endtask

    task automatic t_plain_offset;
        xr[3] = 64'h0000_0000_0000_2000;
        do_op("R3", 2'b10, 7'd5, 5'd1, 5'd2, 5'd3, 1'b0, 1'b1);
        do_op("R3", 2'b10, 7'h3F, 5'd1, 5'd2, 5'd3, 1'b0, 1'b1);
    endtask

    task automatic t_pre_index;
        xr[4] = 64'h0000_0000_0001_0000;
        do_op("R4", 2'b11, 7'h40, 5'd5, 5'd6, 5'd4, 1'b1, 1'b1);
        do_op("R8", 2'b11, 7'h7F, 5'd5, 5'd6, 5'd4, 1'b0, 1'b1);
    endtask

    task automatic t_post_index_stall;
        xr[7] = 64'h0000_0000_0000_4400;
        stall = 1'b1;
        do_op("R5", 2'b01, 7'h3F, 5'd8, 5'd9, 5'd7, 1'b1, 1'b1);
        do_op("R11", 2'b01, 7'h41, 5'd9, 5'd8, 5'd7, 1'b0, 1'b1);
        stall = 1'b0;
    endtask

    task automatic t_sp_base;
        sp_in = 64'h0000_0000_0008_0000;
        do_op("R6", 2'b11, 7'h7E, 5'd1, 5'd2, 5'd31, 1'b0, 1'b1);
        do_op("R6", 2'b01, 7'd2, 5'd1, 5'd2, 5'd31, 1'b1, 1'b1);
    endtask

    task automatic t_misaligned;
        xr[10] = 64'h0000_0000_0000_3008;
        do_op("R7", 2'b01, 7'd1, 5'd1, 5'd2, 5'd10, 1'b0, 1'b1);
        do_op("R7", 2'b10, 7'd0, 5'd1, 5'd2, 5'd10, 1'b0, 1'b1);
        sp_in = 64'h0000_0000_0008_0004;
        do_op("R7", 2'b10, 7'd0, 5'd1, 5'd2, 5'd31, 1'b0, 1'b1);
        sp_in = 64'h0000_0000_0008_0000;
    endtask

    task automatic t_feature_off;
        xr[3] = 64'h0000_0000_0000_2000;
        do_op("R2", 2'b11, 7'd1, 5'd1, 5'd2, 5'd3, 1'b0, 1'b0);
    endtask

    task automatic t_no_match;
        logic [31:0] bad [0:2];
        bad[0] = enc(2'b00, 7'd1, 5'd1, 5'd2, 5'd3);
        bad[1] = enc(2'b10, 7'd1, 5'd1, 5'd2, 5'd3) | 32'h0040_0000;
        bad[2] = enc(2'b11, 7'd1, 5'd1, 5'd2, 5'd3) ^ 32'h8000_0000;
        for (int i = 0; i < 3; i++) begin
            run_word(bad[i], 1'b1, 1'b0);
            chk(!fault_align && !undef && (n_dw + n_tw + n_wb == 0), "R1", "ignored word",
                {fault_align, undef, n_dw[7:0]}, 0);
        end
    endtask

    task automatic t_zero_reg;
        xr[3] = 64'h0000_0000_0000_2000;
        do_op("R10", 2'b10, 7'd0, 5'd31, 5'd2, 5'd3, 1'b0, 1'b1);
        do_op("R10", 2'b10, 7'd0, 5'd1, 5'd31, 5'd3, 1'b1, 1'b1);
    endtask

    task automatic t_tag_bits;
        xr[12] = 64'h0A00_0000_1234_5670;
        do_op("R9", 2'b11, 7'd3, 5'd1, 5'd2, 5'd12, 1'b1, 1'b1);
        xr[12] = 64'hF500_0000_0000_0000;
        do_op("R9", 2'b10, 7'h7F, 5'd1, 5'd2, 5'd12, 1'b0, 1'b1);
    endtask

    task automatic t_single_done;
        int pulses;
        pulses = 0;
        run_word(enc(2'b10, 7'd0, 5'd1, 5'd2, 5'd3), 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done) pulses = pulses + 1;
        end
        chk(pulses == 0 && !busy, "R12", "single done", pulses, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++)
            xr[i] = {32'hC0DE_0000 + 32'(i), 32'h1357_0000 + 32'(i * 3)};
        xr[31] = 64'hDEAD_BEEF_DEAD_BEEF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_offset();
        t_pre_index();
        t_post_index_stall();
        t_sp_base();
        t_misaligned();
        t_feature_off();
        t_no_match();
        t_zero_reg();
        t_tag_bits();
        t_single_done();
        if (timed_out) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL R12 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        end
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule